// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of general-purpose input pins and turns selected pin conditions into interrupt requests. Each pin owns a control word holding a 4-bit detection code that picks one of five conditions: low level, high level, rising edge, falling edge or either edge. Any other code leaves the pin disabled. Pins are brought into the clock domain through a synchronizer chain. Edges are found by comparing each synchronized value with its value one cycle earlier.

When a pin's condition is met, its bit in a shared flag register is set. A single interrupt line stays high while any flag is set. Software reads the flag register to see every pending pin at once and clears flags by writing ones. A level condition that is still present keeps its flag set, so a level source has to go away before its flag can be cleared.

Top module: `gpio_irq_detect`

## Requirements
- R1: The control word of pin n is at byte offset 4*n. Its detection code sits in bits 19:16. Reading the word returns the stored code in bits 19:16 and zero in every other bit. Writes to other bits have no effect.
- R2: Code 0x0 disables the pin, and so does every code other than 0x8, 0x9, 0xA, 0xB and 0xC. A disabled pin never sets its flag.
- R3: Code 0x8 sets the flag while the synchronized pin is 0. Code 0xC sets the flag while it is 1. The flag stays set through a clear for as long as the level is present.
- R4: Code 0x9 sets the flag on a 0-to-1 change of the synchronized pin, 0xA on a 1-to-0 change and 0xB on either change. An edge that has been cleared does not set the flag again while the pin is steady.
- R5: The flag register is at byte offset 0xA0, with bit n belonging to pin n. One read returns all pending pins together.
- R6: Writing the flag register clears each flag whose data bit is 1. Data bits of 0 leave their flags unchanged. Writing all ones clears every flag whose condition is not active.
- R7: When a trigger and a clear hit the same flag in the same cycle, the flag remains set.
- R8: The interrupt output is 1 exactly when at least one flag is set.
- R9: After reset every code is 0x0, every flag is 0 and the interrupt output is 0.
- R10: A pin change sampled at a clock edge shows up in the flag and interrupt output on the third rising clock edge: two synchronizer stages plus the flag register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pins_i | input | 32 | Asynchronous input pins |
| bus_we_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt request, OR of all flags |

## Verification
A corrupted detection code or edge history would show up as a flag bit set or missing in the register read taken a few cycles after the pin changes. A stuck flag would show as a register read or interrupt level that is wrong straight after a clear write. Because each pin has a single flag bit and the interrupt output is the OR of all flags, any wrong internal state reaches the ports within three clock edges of the pin change that exposes it. The sweep applies all sixteen codes to different pins and runs each through low, rising, high and falling phases with clears in between. It also checks the exact three-edge latency and the case where several pins are pending at once.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int MODE_W   = 4;
  localparam int MODE_LSB = 16;

  typedef enum logic [MODE_W-1:0] {
    DET_OFF  = 4'h0,
    DET_LOW  = 4'h8,
    DET_RISE = 4'h9,
    DET_FALL = 4'hA,
    DET_BOTH = 4'hB,
    DET_HIGH = 4'hC
  } det_code_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = async_i;
      end else begin : g_rest
        always_comb stage_d[s] = stage_q[s-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_pin_det.sv
module gpio_irq_pin_det
  import gpio_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              pin_s_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              trig_o
);
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              pin_q;
  logic              rise, fall;

  always_comb mode_d = mode_we_i ? mode_wdata_i : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      pin_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pin_q  <= pin_s_i;
    end
  end

  assign rise = pin_s_i & ~pin_q;
  assign fall = ~pin_s_i & pin_q;

  always_comb begin
    case (mode_q)
      DET_LOW:  trig_o = ~pin_s_i;
      DET_HIGH: trig_o = pin_s_i;
      DET_RISE: trig_o = rise;
      DET_FALL: trig_o = fall;
      DET_BOTH: trig_o = rise | fall;
      default:  trig_o = 1'b0;
    endcase
  end

  assign mode_o = mode_q;

  assert_disabled_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_q inside {DET_LOW, DET_HIGH, DET_RISE, DET_FALL, DET_BOTH}) |-> !trig_o);

  assert_edge_needs_change_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q inside {DET_RISE, DET_FALL, DET_BOTH}) && (pin_s_i == pin_q)) |-> !trig_o);

  assert_mode_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> $stable(mode_q));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] trig_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_mask_i,
  output logic [WIDTH-1:0] flags_o
);
  logic [WIDTH-1:0] flags_q, flags_d, clr_eff;

  always_comb begin
    clr_eff = clr_we_i ? clr_mask_i : '0;
    flags_d = (flags_q & ~clr_eff) | trig_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  assert_trigger_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|trig_i) |=> ((flags_q & $past(trig_i)) == $past(trig_i)));

  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && |(clr_mask_i & ~trig_i)) |=> ((flags_q & $past(clr_mask_i & ~trig_i)) == '0));

  assert_set_has_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(trig_i)) == '0));

  assert_no_write_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int          NUM_PINS    = 32,
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  STATUS_OFF  = 8'hA0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int              IDX_W   = $clog2(NUM_PINS);
  localparam logic [ADDR_W:0] CTL_END = (ADDR_W+1)'(NUM_PINS * 4);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STATUS_OFF);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // address decode
  logic             ctl_hit, stat_hit;
  logic [IDX_W-1:0] ctl_idx;

  assign ctl_hit  = (bus_addr_i[1:0] == 2'b00) && ({1'b0, bus_addr_i} < CTL_END);
  assign stat_hit = (bus_addr_i == STAT_ADDR);
  assign ctl_idx  = bus_addr_i[2 +: IDX_W];

  // pin path
  logic [NUM_PINS-1:0] pins_s, trig, flags;
  logic [MODE_W-1:0]   mode_arr [NUM_PINS];

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (pins_i),
    .sync_o  (pins_s)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      logic mode_we;
      assign mode_we = bus_we_i && ctl_hit && (ctl_idx == IDX_W'(p));
      gpio_irq_pin_det u_det (
        .clk_i        (clk_i),
        .rst_ni       (rst_n),
        .mode_we_i    (mode_we),
        .mode_wdata_i (bus_wdata_i[MODE_LSB +: MODE_W]),
        .pin_s_i      (pins_s[p]),
        .mode_o       (mode_arr[p]),
        .trig_o       (trig[p])
      );
    end
  endgenerate

  gpio_irq_status #(.WIDTH(NUM_PINS)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .trig_i     (trig),
    .clr_we_i   (bus_we_i && stat_hit),
    .clr_mask_i (bus_wdata_i[NUM_PINS-1:0]),
    .flags_o    (flags)
  );

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (ctl_hit) begin
      bus_rdata_o[MODE_LSB +: MODE_W] = mode_arr[ctl_idx];
    end else if (stat_hit) begin
      bus_rdata_o[NUM_PINS-1:0] = flags;
    end
  end

  assign irq_o = |flags;

  assert_irq_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!(|trig) && bus_we_i && stat_hit && (&bus_wdata_i[NUM_PINS-1:0])) |=> !irq_o);

  assert_irq_after_trig_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|trig) |=> irq_o);
endmodule

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pins;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_detect dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pins_i      (pins),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; pins = '0; we = 1'b0; addr = '0; wdata = '0;
    edges(3);
    @(negedge clk) rst_n = 1'b1;
    edges(4);

    // R9 reset state
    rd(8'hA0, v); check("R9 flags after reset", v, 32'h0);
    check("R9 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h14, v); check("R9 code after reset", v, 32'h0);

    // sweep of all sixteen codes, each on its own pin
    for (int code = 0; code < 16; code++) begin
      int p;
      bit lo, hi, ri, fa;
      p  = (code * 5 + 1) % 32;
      lo = (code == 8); hi = (code == 12);
      ri = (code == 9) || (code == 11);
      fa = (code == 10) || (code == 11);

      wr(8'(p * 4), {12'hFFF, 4'(code), 16'hFFFF});
      rd(8'(p * 4), v);
      check("R1 code readback", v, {12'h0, 4'(code), 16'h0});

      // pin low, clear, level-low must persist (R3, R7)
      edges(4);
      wr(8'hA0, 32'hFFFF_FFFF);
      rd(8'hA0, v);
      check("R3 low phase after clear", v, lo ? (32'h1 << p) : 32'h0);

      // rising change (R4), code 8 flag is still held
      @(negedge clk) pins[p] = 1'b1;
      edges(4);
      rd(8'hA0, v);
      check("R4 after rise", v, (lo || hi || ri) ? (32'h1 << p) : 32'h0);
      check("R8 irq after rise", {31'b0, irq}, {31'b0, (lo || hi || ri)});

      // clear while high: only level-high remains (R3, R6)
      wr(8'hA0, 32'hFFFF_FFFF);
      rd(8'hA0, v);
      check("R6 high phase after clear", v, hi ? (32'h1 << p) : 32'h0);

      // falling change (R4)
      @(negedge clk) pins[p] = 1'b0;
      edges(4);
      rd(8'hA0, v);
      check("R4 after fall", v, (lo || hi || fa) ? (32'h1 << p) : 32'h0);

      wr(8'hA0, 32'hFFFF_FFFF);
      rd(8'hA0, v);
      check("R3 low phase second clear", v, lo ? (32'h1 << p) : 32'h0);

      // disable and clear (R2)
      wr(8'(p * 4), 32'h0);
      wr(8'hA0, 32'hFFFF_FFFF);
      rd(8'hA0, v);
      check("R2 disabled pin quiet", v, 32'h0);
      check("R8 irq low when no flag", {31'b0, irq}, 32'h0);
    end

    // R10 latency: rising on pin 7
    wr(8'd28, 32'h0009_0000);
    edges(2);
    @(negedge clk) pins[7] = 1'b1;
    edges(2);
    @(negedge clk) check("R10 no flag after two edges", {31'b0, irq}, 32'h0);
    edges(1);
    @(negedge clk) check("R10 flag on third edge", {31'b0, irq}, 32'h1);
    wr(8'd28, 32'h0);
    wr(8'hA0, 32'hFFFF_FFFF);
    @(negedge clk) pins[7] = 1'b0;
    edges(4);

    // several pending pins, selective clear (R5, R6)
    wr(8'd12,  32'h000B_0000);
    wr(8'd80,  32'h000B_0000);
    wr(8'd124, 32'h000B_0000);
    @(negedge clk) pins = 32'h8010_0008;
    edges(4);
    rd(8'hA0, v); check("R5 multiple pending", v, 32'h8010_0008);
    wr(8'hA0, 32'h0010_0000);
    rd(8'hA0, v); check("R6 clear one bit", v, 32'h8000_0008);
    wr(8'hA0, 32'h0);
    rd(8'hA0, v); check("R6 zero write no effect", v, 32'h8000_0008);
    check("R8 irq with two flags", {31'b0, irq}, 32'h1);
    wr(8'h84, 32'hFFFF_FFFF);
    rd(8'hA0, v); check("R5 unmapped write ignored", v, 32'h8000_0008);
    wr(8'hA0, 32'hFFFF_FFFF);
    rd(8'hA0, v); check("R6 all ones clears", v, 32'h0);
    check("R8 irq cleared", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule